// File: doc/BRIEF.md
# ROM/SRAM Asynchronous Bus Cycle Controller

This block sits on the host side of a combined memory device that holds a read-only array and a small static RAM behind one shared address and data bus. Each array has its own active-low select. The block takes single clocked requests and turns each one into a correctly timed asynchronous bus cycle. A request names a target (ROM or SRAM), a direction, an address and write data. When the access ends, the block returns read data together with a done pulse that lasts one cycle.

Every device timing minimum is given in nanoseconds as a parameter. The clock period is also a parameter. Each minimum becomes a cycle count by ceiling division, and no count is allowed below one. The controller never drives both selects low at the same time. When consecutive accesses change target, it keeps both selects high for a dead-time gap. Only the SRAM is ever written. A write aimed at the ROM completes as a no-op.

At the default 8 ns clock the derived lengths are:

| Quantity | Cycles |
|---|---|
| Read cycle | 63 |
| Write cycle | 63 |
| Write-enable pulse (the last cycles of a write) | 25 |
| Select gap | 2 |

Top module: `dualmem_cycle_ctrl`

## Requirements
- R1: A read holds its select low and `oeN` low for exactly `ceil(max(tRC, tAA, tOE) / period)` cycles (63 at defaults), with `weN` high and `memAddr` unchanged throughout.
- R2: Read data is captured at the clock edge that ends the last low-select cycle. It appears on `rspData` in the same cycle as `rspDone`. The captured value is the device byte at the access address.
- R3: An SRAM write holds `ramSelN` low for `ceil(max(tWC, tCW, tWP, tDW) / period)` cycles (63). `weN` is low for the final `ceil(max(tWP, tDW) / period)` cycles (25) and rises together with `ramSelN`.
- R4: `memDriveEn` is high exactly while `weN` is low and for the one cycle after `weN` rises. It is never high while `oeN` is low.
- R5: `romSelN` and `ramSelN` are never low in the same cycle.
- R6: When an access targets the other array than the previous device access did, `ceil(tGap / period)` extra cycles (2) pass before the new select falls. An access to the same array starts its cycle on the first cycle after acceptance.
- R7: During SRAM accesses, `memAddr` bits above bit 14 are driven 0. During ROM accesses, all 18 address bits are driven as requested.
- R8: A write request with `reqTarget` = 0 (ROM) drives no select, no `weN` and no data. `rspDone` pulses in the cycle after acceptance, and `rspData` keeps its previous value.
- R9: `reqReady` is high only when the controller is idle. A request is taken only at an edge where `reqReady` and `reqValid` are both high. `reqValid` pulses while busy are ignored.
- R10: `rspDone` lasts exactly one cycle per access. `rspData` changes only in the `rspDone` cycle of a read.
- R11: During and right after reset, both selects, `oeN` and `weN` are high, `memDriveEn` and `rspDone` are low, `reqReady` is high, and `rspData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe |
| reqReady | output | 1 | Controller idle, request can be taken |
| reqTarget | input | 1 | 0 = ROM, 1 = SRAM |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Request address |
| reqWdata | input | 8 | Write data |
| rspDone | output | 1 | One-cycle completion pulse |
| rspData | output | 8 | Last read data, held |
| memAddr | output | 18 | Device address |
| romSelN | output | 1 | ROM select, active low |
| ramSelN | output | 1 | SRAM select, active low |
| oeN | output | 1 | Output enable, active low |
| weN | output | 1 | Write enable, active low |
| memWdata | output | 8 | Write data toward the device |
| memDriveEn | output | 1 | Enable of the host data driver |
| memRdata | input | 8 | Data read from the device |

## Verification
The main function is tried with several access patterns:
- Back-to-back ROM reads to the same array, which show that no dead time is inserted.
- Changes of target from ROM to SRAM and back, which must show the two-cycle gap.
- SRAM writes followed by reads of the same location. The write address carries high bits that must be masked, so these show both the masking and that the data really reached the device.
- A ROM write, which must complete without touching the bus.
- A request pulsed while an access is in flight, which must leave the bus untouched.

Pulse widths, select-low lengths and gaps are measured independently of the per-cycle reference, so a wrong derived cycle count is separated from a wrong state sequence.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GAP,
    ST_ACCESS,
    ST_DONE
  } ctrl_state_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadReq;
    logic captureRd;
  } dmc_strobe_t;

  // nanosecond minimum to whole clock cycles, never below one
  function automatic int ceilCycles(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dmc_datapath.sv
module dmc_datapath
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int RAM_ADDR_W = 15,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmc_strobe_t       strobe,
  input  logic              reqTarget,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              curTarget,
  output logic              curWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] rspData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              targetQ;
  logic              writeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      targetQ <= 1'b0;
      writeQ  <= 1'b0;
    end else if (strobe.loadReq) begin
      addrQ   <= reqAddr;
      wdataQ  <= reqWdata;
      targetQ <= reqTarget;
      writeQ  <= reqWrite;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdataQ <= '0;
    else if (strobe.captureRd) rdataQ <= memRdata;
  end

  // SRAM sees only its low address bits; upper lines are forced low
  generate
    if (RAM_ADDR_W < ADDR_W) begin : g_mask
      localparam int HI_W = ADDR_W - RAM_ADDR_W;
      assign memAddr = targetQ ? {{HI_W{1'b0}}, addrQ[RAM_ADDR_W-1:0]} : addrQ;
    end else begin : g_full
      assign memAddr = addrQ;
    end
  endgenerate

  assign memWdata  = wdataQ;
  assign rspData   = rdataQ;
  assign curTarget = targetQ;
  assign curWrite  = writeQ;

endmodule

// File: rtl/dmc_control.sv
module dmc_control
  import dmc_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_RC_NS       = 500,
  parameter int T_AA_NS       = 450,
  parameter int T_OE_NS       = 200,
  parameter int T_WC_NS       = 500,
  parameter int T_WP_NS       = 200,
  parameter int T_CW_NS       = 220,
  parameter int T_DW_NS       = 100,
  parameter int T_GAP_NS      = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqTarget,
  input  logic        reqWrite,
  input  logic        curTarget,
  input  logic        curWrite,
  output dmc_strobe_t strobe,
  output logic        reqReady,
  output logic        rspDone,
  output logic        romSelN,
  output logic        ramSelN,
  output logic        oeN,
  output logic        weN,
  output logic        memDriveEn
);

  localparam int RD_LEN  = maxOf(ceilCycles(T_RC_NS, CLK_PERIOD_NS),
                                 maxOf(ceilCycles(T_AA_NS, CLK_PERIOD_NS),
                                       ceilCycles(T_OE_NS, CLK_PERIOD_NS)));
  localparam int WP_LEN  = maxOf(ceilCycles(T_WP_NS, CLK_PERIOD_NS),
                                 ceilCycles(T_DW_NS, CLK_PERIOD_NS));
  localparam int WR_LEN  = maxOf(ceilCycles(T_WC_NS, CLK_PERIOD_NS),
                                 maxOf(ceilCycles(T_CW_NS, CLK_PERIOD_NS), WP_LEN));
  localparam int GAP_LEN = ceilCycles(T_GAP_NS, CLK_PERIOD_NS);
  localparam int MAX_LEN = maxOf(maxOf(RD_LEN, WR_LEN), GAP_LEN);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_LEN - 1);
  localparam logic [CNT_W-1:0] WR_LAST  = CNT_W'(WR_LEN - 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_LEN - 1);
  localparam logic [CNT_W-1:0] WE_START = CNT_W'(WR_LEN - WP_LEN);

  ctrl_state_e       state, stateNext;
  logic [CNT_W-1:0]  cnt, cntNext;
  logic              lastTarget, hasLast;
  logic              accept, romWrite, switchTgt, accessEnd, inAccess, weActive;
  logic [CNT_W-1:0]  lastCnt;

  assign accept    = (state == ST_IDLE) && reqValid;
  assign romWrite  = reqWrite && !reqTarget;
  assign switchTgt = hasLast && (reqTarget != lastTarget);
  assign lastCnt   = curWrite ? WR_LAST : RD_LAST;
  assign inAccess  = (state == ST_ACCESS);
  assign accessEnd = inAccess && (cnt == lastCnt);
  assign weActive  = inAccess && curWrite && curTarget && (cnt >= WE_START);

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    unique case (state)
      ST_IDLE: begin
        cntNext = '0;
        if (accept) begin
          if (romWrite)       stateNext = ST_DONE;
          else if (switchTgt) stateNext = ST_GAP;
          else                stateNext = ST_ACCESS;
        end
      end
      ST_GAP: begin
        if (cnt == GAP_LAST) begin
          stateNext = ST_ACCESS;
          cntNext   = '0;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      ST_ACCESS: begin
        if (accessEnd) begin
          stateNext = ST_DONE;
          cntNext   = '0;
        end else begin
          cntNext = cnt + 1'b1;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      lastTarget <= 1'b0;
      hasLast    <= 1'b0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
      if (accept && !romWrite) begin
        lastTarget <= reqTarget;
        hasLast    <= 1'b1;
      end
    end
  end

  assign strobe.loadReq   = accept;
  assign strobe.captureRd = accessEnd && !curWrite;

  assign reqReady   = (state == ST_IDLE);
  assign rspDone    = (state == ST_DONE);
  assign romSelN    = !(inAccess && !curTarget);
  assign ramSelN    = !(inAccess && curTarget);
  assign oeN        = !(inAccess && !curWrite);
  assign weN        = !weActive;
  assign memDriveEn = weActive || ((state == ST_DONE) && curWrite && curTarget);

endmodule

// File: rtl/dualmem_cycle_ctrl.sv
module dualmem_cycle_ctrl
  import dmc_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 8,
  parameter int ADDR_W        = 18,
  parameter int RAM_ADDR_W    = 15,
  parameter int DATA_W        = 8,
  parameter int T_RC_NS       = 500,
  parameter int T_AA_NS       = 450,
  parameter int T_OE_NS       = 200,
  parameter int T_WC_NS       = 500,
  parameter int T_WP_NS       = 200,
  parameter int T_CW_NS       = 220,
  parameter int T_DW_NS       = 100,
  parameter int T_GAP_NS      = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqTarget,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              romSelN,
  output logic              ramSelN,
  output logic              oeN,
  output logic              weN,
  output logic [DATA_W-1:0] memWdata,
  output logic              memDriveEn,
  input  logic [DATA_W-1:0] memRdata
);

  dmc_strobe_t strobe;
  logic        curTarget;
  logic        curWrite;

  dmc_control #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS), .T_RC_NS(T_RC_NS), .T_AA_NS(T_AA_NS),
    .T_OE_NS(T_OE_NS), .T_WC_NS(T_WC_NS), .T_WP_NS(T_WP_NS),
    .T_CW_NS(T_CW_NS), .T_DW_NS(T_DW_NS), .T_GAP_NS(T_GAP_NS)
  ) u_control (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqTarget(reqTarget),
    .reqWrite(reqWrite), .curTarget(curTarget), .curWrite(curWrite),
    .strobe(strobe), .reqReady(reqReady), .rspDone(rspDone),
    .romSelN(romSelN), .ramSelN(ramSelN), .oeN(oeN), .weN(weN),
    .memDriveEn(memDriveEn)
  );

  dmc_datapath #(
    .ADDR_W(ADDR_W), .RAM_ADDR_W(RAM_ADDR_W), .DATA_W(DATA_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqTarget(reqTarget),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .memRdata(memRdata), .curTarget(curTarget), .curWrite(curWrite),
    .memAddr(memAddr), .memWdata(memWdata), .rspData(rspData)
  );

endmodule

// File: rtl/dmc_checker.sv
module dmc_checker
  import dmc_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 8,
  parameter int ADDR_W        = 18,
  parameter int RAM_ADDR_W    = 15,
  parameter int DATA_W        = 8,
  parameter int T_GAP_NS      = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspDone,
  input logic [DATA_W-1:0] rspData,
  input logic [ADDR_W-1:0] memAddr,
  input logic              romSelN,
  input logic              ramSelN,
  input logic              oeN,
  input logic              weN,
  input logic              memDriveEn
);

  localparam int GAP_LEN = ceilCycles(T_GAP_NS, CLK_PERIOD_NS);
  localparam int GW      = $clog2(GAP_LEN + 1);
  localparam logic [GW-1:0] GAP_CAP = GW'(GAP_LEN);

  // cycles since each select was last low, saturating at the gap length
  logic [GW-1:0] sinceRom, sinceRam;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRom <= GAP_CAP;
      sinceRam <= GAP_CAP;
    end else begin
      sinceRom <= !romSelN ? '0 : ((sinceRom < GAP_CAP) ? sinceRom + 1'b1 : sinceRom);
      sinceRam <= !ramSelN ? '0 : ((sinceRam < GAP_CAP) ? sinceRam + 1'b1 : sinceRam);
    end
  end

  assert_sel_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(!romSelN && !ramSelN));

  assert_gap_to_ram_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ramSelN) |-> (sinceRom >= GAP_CAP));

  assert_gap_to_rom_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(romSelN) |-> (sinceRam >= GAP_CAP));

  assert_we_sram_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> (!ramSelN && romSelN && oeN));

  assert_no_drive_on_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> !memDriveEn);

  assert_drive_with_we_R4: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> memDriveEn);

  assert_drive_after_we_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(weN) |-> memDriveEn);

  assert_addr_stable_ram_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!ramSelN && $past(!ramSelN)) |-> $stable(memAddr));

  assert_addr_stable_rom_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!romSelN && $past(!romSelN)) |-> $stable(memAddr));

  assert_sram_upper_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ramSelN |-> (memAddr[ADDR_W-1:RAM_ADDR_W] == '0));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rspData) |-> rspDone);

  assert_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid) |=> !reqReady);

endmodule

bind dualmem_cycle_ctrl dmc_checker #(
  .CLK_PERIOD_NS(CLK_PERIOD_NS), .ADDR_W(ADDR_W), .RAM_ADDR_W(RAM_ADDR_W),
  .DATA_W(DATA_W), .T_GAP_NS(T_GAP_NS)
) u_dmc_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspDone(rspDone), .rspData(rspData), .memAddr(memAddr),
  .romSelN(romSelN), .ramSelN(ramSelN), .oeN(oeN), .weN(weN),
  .memDriveEn(memDriveEn)
);

// File: tb/test_dualmem_cycle_ctrl.sv
module test_dualmem_cycle_ctrl;

  localparam int PER = 8;
  function automatic int cyc(input int ns);
    int c;
    c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_LEN  = mx(cyc(500), mx(cyc(450), cyc(200)));
  localparam int WP_LEN  = mx(cyc(200), cyc(100));
  localparam int WR_LEN  = mx(cyc(500), mx(cyc(220), WP_LEN));
  localparam int GAP_LEN = cyc(10);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqTarget = 1'b0, reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic [7:0]  memRdata = '0;
  logic        reqReady, rspDone, romSelN, ramSelN, oeN, weN, memDriveEn;
  logic [7:0]  rspData, memWdata;
  logic [17:0] memAddr;

  dualmem_cycle_ctrl i_dualmem_cycle_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqTarget(reqTarget), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rspDone(rspDone), .rspData(rspData),
    .memAddr(memAddr), .romSelN(romSelN), .ramSelN(ramSelN), .oeN(oeN),
    .weN(weN), .memWdata(memWdata), .memDriveEn(memDriveEn),
    .memRdata(memRdata)
  );

  always #4 clk = ~clk;

  int nCmp = 0, nBad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] romByte(input logic [17:0] a);
    return a[7:0] ^ a[15:8] ^ {a[17:16], 6'h15};
  endfunction

  // bench device SRAM and the reference's own copy of expected contents
  logic [7:0] devMem [int];
  logic [7:0] expMem [int];

  // behavioural reference: phase 0 idle, 1 gap, 2 access, 3 done
  int          mPhase, mCnt, mLen;
  logic        mTgt, mWr, mHasLast, mLastTgt;
  logic [17:0] mAddr;
  logic [7:0]  mWdata, mRdata;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase <= 0; mCnt <= 0; mLen <= 0; mTgt <= 0; mWr <= 0;
      mHasLast <= 0; mLastTgt <= 0; mAddr <= '0; mWdata <= '0; mRdata <= '0;
    end else begin
      case (mPhase)
        0: if (reqValid) begin
             mTgt <= reqTarget; mWr <= reqWrite; mAddr <= reqAddr;
             mWdata <= reqWdata; mCnt <= 0;
             mLen <= reqWrite ? WR_LEN : RD_LEN;
             if (reqWrite && !reqTarget) mPhase <= 3;
             else begin
               mPhase <= (mHasLast && mLastTgt != reqTarget) ? 1 : 2;
               mHasLast <= 1; mLastTgt <= reqTarget;
             end
           end
        1: if (mCnt == GAP_LEN - 1) begin mPhase <= 2; mCnt <= 0; end
           else mCnt <= mCnt + 1;
        2: if (mCnt == mLen - 1) begin
             mPhase <= 3; mCnt <= 0;
             if (mWr) expMem[int'(mAddr[14:0])] = mWdata;
             else if (mTgt) mRdata <= expMem.exists(int'(mAddr[14:0])) ? expMem[int'(mAddr[14:0])] : 8'h00;
             else mRdata <= romByte(mAddr);
           end else mCnt <= mCnt + 1;
        default: mPhase <= 0;
      endcase
    end
  end

  // independent pulse measurements
  int   selLow = 0, weLow = 0, highRun = 1000, lastSel = -1;
  logic prevRom = 1, prevRam = 1, prevWe = 1, sawWe = 0;
  logic started = 0;

  always @(negedge clk) begin
    if (started && rstN) begin
      logic inAcc, eRom, eRam, eOe, eWe, eDrv;
      inAcc = (mPhase == 2);
      eRom = !(inAcc && !mTgt);
      eRam = !(inAcc && mTgt);
      eOe  = !(inAcc && !mWr);
      eWe  = !(inAcc && mWr && mTgt && mCnt >= WR_LEN - WP_LEN);
      eDrv = !eWe || (mPhase == 3 && mWr && mTgt);
      chk("R1/R5 romSelN", romSelN, eRom);
      chk("R3/R5 ramSelN", ramSelN, eRam);
      chk("R1 oeN", oeN, eOe);
      chk("R3 weN", weN, eWe);
      chk("R4 memDriveEn", memDriveEn, eDrv);
      chk("R9 reqReady", reqReady, mPhase == 0);
      chk("R10 rspDone", rspDone, mPhase == 3);
      chk("R2 rspData", rspData, mRdata);
      chk("R7 memAddr", memAddr, mTgt ? {3'b000, mAddr[14:0]} : mAddr);
      if (!memDriveEn == 0 && mWr) chk("R3 memWdata", memWdata, mWdata);
      // measurements: select low length, WE width, target-switch gap
      if (!weN) begin weLow++; sawWe = 1; end
      if (!weN == 0 && !prevWe) begin chk("R3 WE low width", weLow, WP_LEN); weLow = 0; end
      if (!romSelN || !ramSelN) selLow++;
      if ((romSelN && !prevRom) || (ramSelN && !prevRam)) begin
        chk("R1/R3 select low length", selLow, sawWe ? WR_LEN : RD_LEN);
        selLow = 0; sawWe = 0;
      end
      if (!ramSelN && prevRam && lastSel == 0) chk("R6 gap to SRAM", highRun >= GAP_LEN, 1);
      if (!romSelN && prevRom && lastSel == 1) chk("R6 gap to ROM", highRun >= GAP_LEN, 1);
      if (!romSelN) begin lastSel = 0; highRun = 0; end
      else if (!ramSelN) begin lastSel = 1; highRun = 0; end
      else highRun++;
      prevRom = romSelN; prevRam = ramSelN; prevWe = weN;
      // bench device
      if (!ramSelN && !weN && memDriveEn) devMem[int'(memAddr[14:0])] = memWdata;
      if (!romSelN && !oeN) memRdata = romByte(memAddr);
      else if (!ramSelN && !oeN && weN)
        memRdata = devMem.exists(int'(memAddr[14:0])) ? devMem[int'(memAddr[14:0])] : 8'h00;
      else memRdata = 8'hEE;
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nCmp++; nBad++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  task automatic doReq(input logic tgt, input logic wr, input logic [17:0] a, input logic [7:0] d);
    while (reqReady !== 1'b1) @(negedge clk);
    reqValid = 1; reqTarget = tgt; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 0;
    @(negedge clk);
    while (reqReady !== 1'b1) @(negedge clk);
  endtask

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 romSelN", romSelN, 1); chk("R11 ramSelN", ramSelN, 1);
    chk("R11 oeN", oeN, 1); chk("R11 weN", weN, 1);
    chk("R11 drive", memDriveEn, 0); chk("R11 done", rspDone, 0);
    chk("R11 ready", reqReady, 1); chk("R11 rspData", rspData, 0);
    rstN = 1; started = 1;
    @(negedge clk);
    chk("R11 ready after reset", reqReady, 1);
    doReq(0, 0, 18'h31234, 8'h00);                      // ROM read
    chk("R2 rom read data", rspData, romByte(18'h31234));
    doReq(0, 0, 18'h00055, 8'h00);                      // ROM read, no gap R6
    doReq(1, 1, 18'h20123, 8'hA5);                      // SRAM write, switch R6, mask R7
    doReq(1, 0, 18'h00123, 8'h00);                      // SRAM read back
    chk("R2 sram readback", rspData, 8'hA5);
    doReq(1, 1, 18'h07FFF, 8'h3C);
    held = rspData;
    doReq(0, 1, 18'h00777, 8'h99);                      // ROM write: no-op R8
    chk("R8 rspData unchanged", rspData, held);
    chk("R8 no device write", devMem.exists(int'(15'h0777)), 0);
    doReq(1, 0, 18'h37FFF, 8'h00);                      // SRAM read, upper bits masked
    chk("R2 sram upper masked", rspData, 8'h3C);
    // R9: request pulsed while busy is ignored
    while (reqReady !== 1'b1) @(negedge clk);
    reqValid = 1; reqTarget = 0; reqWrite = 0; reqAddr = 18'h2ABCD;
    @(negedge clk);
    reqValid = 0;
    repeat (10) @(negedge clk);
    reqValid = 1; reqTarget = 1; reqWrite = 1; reqAddr = 18'h00001; reqWdata = 8'h77;
    @(negedge clk);
    reqValid = 0;
    chk("R9 busy address held", memAddr, 18'h2ABCD);
    while (reqReady !== 1'b1) @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R9 ignored request left idle", reqReady, 1);
    chk("R9 ignored write absent", devMem.exists(1), 0);
    chk("R2 rom read after switch", rspData, romByte(18'h2ABCD));
    doReq(1, 0, 18'h00123, 8'h00);
    chk("R2 sram retains", rspData, 8'hA5);
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule